// File: doc/BRIEF.md
# Four-input by thirty-two-output packet arbiter stage

This block is one first-level stage of a two-level high-radix switch. Four input ports feed thirty-two output ports. Each input has exactly one queue, and the attached end node fills it under credit-based flow control. There are no per-destination queues. Every cycle an arbiter inspects the head flit of each queue. For each output it names the input that may drive that output's 4:1 selector. Several inputs can advance in the same cycle when their destinations differ.

A packet is 1 to 6 flits long, and each flit carries head and tail markers. A grant on an output stays with one input from the head flit to the tail flit, so packets never interleave on an output. Inputs that compete for an idle output are served round-robin. The round-robin pointer moves only when a packet ends. A grant also needs a downstream credit for the chosen output. One credit goes back to the end node for every flit that leaves an input queue. A stalled head flit blocks every flit behind it in the same queue. The small input count keeps that blocking rare.

Top module: `asym_subswitch`

## Requirements
- R1: During and directly after reset no output carries a grant, no input forwards a flit and no credit is returned. Every output starts with DOWN_DEPTH downstream credits and every queue starts empty.
- R2: A flit written into an empty queue is forwarded (fwd_vld_o high) in the next cycle, provided its output is idle and has a credit.
- R3: credit_o[i] is high for exactly one cycle, the cycle after each flit leaves queue i.
- R4: Once an output grants the head flit (head=1, tail=0) of a packet, it grants no other input until that packet's tail flit has left. A flit with head=1 and tail=1 is a whole packet.
- R5: Among inputs whose head flits want the same idle output, the winner is the first requester at or after that output's pointer, in ascending index order with wrap. Every pointer resets to input 0 and moves to one past the winner when the winner's tail flit leaves.
- R6: Inputs whose head flits want different outputs are all forwarded in the same cycle.
- R7: A head flit that cannot advance keeps every later flit of its queue waiting, even when their outputs are idle and credited.
- R8: Each grant uses one credit of its output. A pulse on out_cred_i[d] adds one. An output with zero credits grants nothing, and granting resumes in the cycle after a credit returns.
- R9: Each queue holds BUF_DEPTH flits and forwards them in arrival order.
- R10: in_dest_i carries the binary output index of each input's flit, 5 bits per input with input i at bits [5i+4:5i]. gnt_src_o[2d+1:2d] carries the binary index of the input granted on output d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 4 | Flit write strobe per input |
| in_head_i | input | 4 | First-flit marker per input |
| in_tail_i | input | 4 | Last-flit marker per input |
| in_dest_i | input | 20 | Destination output index, 5 bits per input |
| in_data_i | input | 64 | Flit payload, 16 bits per input |
| credit_o | output | 4 | Credit back to the end node per input |
| fwd_vld_o | output | 4 | Head flit of the input leaves this cycle |
| fwd_head_o | output | 4 | First-flit marker of the forwarded flit |
| fwd_tail_o | output | 4 | Last-flit marker of the forwarded flit |
| fwd_data_o | output | 64 | Head flit payload, 16 bits per input |
| out_cred_i | input | 32 | Downstream credit return pulse per output |
| gnt_vld_o | output | 32 | Output carries a grant this cycle |
| gnt_src_o | output | 64 | Granted input index, 2 bits per output |

## Verification
A flit is written on a clock edge and appears at the queue head after that edge. Grants and forward strobes are combinational from the queue heads and arbiter state, so the bench samples them at the falling edge that follows the write. credit_o comes from a register and is sampled one falling edge later still. A credit pulse is counted on the rising edge after it is driven, so the freed grant is checked at the next falling edge. Inputs and credit returns change only at falling edges, which keeps every sample in the middle of the cycle and clear of the edge that updates state.

// File: rtl/asw_pkg.sv
package asw_pkg;
  localparam int unsigned DEF_N_IN       = 4;
  localparam int unsigned DEF_N_OUT      = 32;
  localparam int unsigned DEF_DATA_W     = 16;
  localparam int unsigned DEF_BUF_DEPTH  = 8;
  localparam int unsigned DEF_DOWN_DEPTH = 4;
endpackage

// File: rtl/asw_flit_fifo.sv
module asw_flit_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         full;

  assign empty_o = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign dout_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
    end
  end

  // end node must respect its credits
  a_r9_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);
  // arbiter only grants a present flit
  a_r3_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/asw_out_arb.sv
module asw_out_arb #(
  parameter int unsigned N_IN       = 4,
  parameter int unsigned DOWN_DEPTH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0]         req_i,
  input  logic [N_IN-1:0]         tail_i,
  input  logic                    cred_ret_i,
  output logic                    gnt_vld_o,
  output logic [$clog2(N_IN)-1:0] gnt_src_o
);
  localparam int unsigned IN_W  = $clog2(N_IN);
  localparam int unsigned CNT_W = $clog2(DOWN_DEPTH + 1);

  logic             locked_q;
  logic [IN_W-1:0]  owner_q, ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IN_W-1:0]  win, idx, cand;
  logic             found, cand_vld;

  // round-robin pick starting at ptr_q
  always_comb begin
    win   = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < int'(N_IN); k++) begin
      idx = ptr_q + IN_W'(k);
      if (!found && req_i[idx]) begin
        win   = idx;
        found = 1'b1;
      end
    end
  end

  assign cand      = locked_q ? owner_q : win;
  assign cand_vld  = locked_q ? req_i[owner_q] : found;
  assign gnt_vld_o = cand_vld && (cnt_q != '0);
  assign gnt_src_o = cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
      cnt_q    <= CNT_W'(DOWN_DEPTH);
    end else begin
      cnt_q <= cnt_q - CNT_W'(gnt_vld_o) + CNT_W'(cred_ret_i);
      if (gnt_vld_o) begin
        if (tail_i[cand]) begin
          locked_q <= 1'b0;
          ptr_q    <= cand + 1'b1;
        end else begin
          locked_q <= 1'b1;
          owner_q  <= cand;
        end
      end
    end
  end

  a_r4_packet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && !tail_i[gnt_src_o]) |=> (!gnt_vld_o || gnt_src_o == $past(gnt_src_o)));
  a_r8_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DOWN_DEPTH));
  a_r8_credit_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && !cred_ret_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/asym_subswitch.sv
module asym_subswitch
  import asw_pkg::*;
#(
  parameter int unsigned N_IN       = DEF_N_IN,
  parameter int unsigned N_OUT      = DEF_N_OUT,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned BUF_DEPTH  = DEF_BUF_DEPTH,
  parameter int unsigned DOWN_DEPTH = DEF_DOWN_DEPTH
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_IN-1:0]                  in_vld_i,
  input  logic [N_IN-1:0]                  in_head_i,
  input  logic [N_IN-1:0]                  in_tail_i,
  input  logic [N_IN*$clog2(N_OUT)-1:0]    in_dest_i,
  input  logic [N_IN*DATA_W-1:0]           in_data_i,
  output logic [N_IN-1:0]                  credit_o,
  output logic [N_IN-1:0]                  fwd_vld_o,
  output logic [N_IN-1:0]                  fwd_head_o,
  output logic [N_IN-1:0]                  fwd_tail_o,
  output logic [N_IN*DATA_W-1:0]           fwd_data_o,
  input  logic [N_OUT-1:0]                 out_cred_i,
  output logic [N_OUT-1:0]                 gnt_vld_o,
  output logic [N_OUT*$clog2(N_IN)-1:0]    gnt_src_o
);
  localparam int unsigned IN_W  = $clog2(N_IN);
  localparam int unsigned OUT_W = $clog2(N_OUT);
  localparam int unsigned ENT_W = 2 + OUT_W + DATA_W;

  logic [ENT_W-1:0]  ent [N_IN];
  logic [N_IN-1:0]   emp, fire, h_head, h_tail;
  logic [OUT_W-1:0]  h_dest [N_IN];
  logic [DATA_W-1:0] h_data [N_IN];
  logic [N_IN-1:0]   req_m [N_OUT];
  logic [IN_W-1:0]   gnt_src [N_OUT];
  logic [N_OUT-1:0]  hit [N_IN];
  logic [N_IN-1:0]   credit_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    asw_flit_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_vld_i[i]),
      .din_i   ({in_head_i[i], in_tail_i[i],
                 in_dest_i[i*OUT_W +: OUT_W], in_data_i[i*DATA_W +: DATA_W]}),
      .pop_i   (fire[i]),
      .dout_o  (ent[i]),
      .empty_o (emp[i])
    );
    assign {h_head[i], h_tail[i], h_dest[i], h_data[i]} = ent[i];
    assign fwd_data_o[i*DATA_W +: DATA_W] = h_data[i];

    a_r6_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit[i]) <= 1);
    a_r7_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!emp[i] && !fire[i]) |=> ($stable(h_data[i]) && $stable(h_dest[i])));
  end

  // request matrix: output d sees every non-empty input whose head targets d
  always_comb begin
    for (int d = 0; d < int'(N_OUT); d++) begin
      for (int i = 0; i < int'(N_IN); i++) begin
        req_m[d][i] = !emp[i] && (h_dest[i] == OUT_W'(d));
      end
    end
  end

  for (genvar d = 0; d < N_OUT; d++) begin : g_out
    asw_out_arb #(.N_IN(N_IN), .DOWN_DEPTH(DOWN_DEPTH)) u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_m[d]),
      .tail_i     (h_tail),
      .cred_ret_i (out_cred_i[d]),
      .gnt_vld_o  (gnt_vld_o[d]),
      .gnt_src_o  (gnt_src[d])
    );
    assign gnt_src_o[d*IN_W +: IN_W] = gnt_src[d];
  end

  always_comb begin
    for (int i = 0; i < int'(N_IN); i++) begin
      for (int d = 0; d < int'(N_OUT); d++) begin
        hit[i][d] = gnt_vld_o[d] && (gnt_src[d] == IN_W'(i));
      end
      fire[i] = |hit[i];
    end
  end

  assign fwd_vld_o  = fire;
  assign fwd_head_o = h_head;
  assign fwd_tail_o = h_tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= fire;
  end
  assign credit_o = credit_q;
endmodule

// File: tb/asym_subswitch_test.sv
module asym_subswitch_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  b_vld = '0, b_head = '0, b_tail = '0;
  logic [19:0] b_dest = '0;
  logic [63:0] b_data = '0;
  logic [3:0]  credit_o, fwd_vld_o, fwd_head_o, fwd_tail_o;
  logic [63:0] fwd_data_o, gnt_src_o;
  logic [31:0] gnt_vld_o, out_cred, ret_q = '0, man_ret = '0;
  logic        auto_ret = 1'b1;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  always @(negedge clk) ret_q <= gnt_vld_o;
  assign out_cred = auto_ret ? ret_q : man_ret;

  asym_subswitch uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_vld_i(b_vld), .in_head_i(b_head),
    .in_tail_i(b_tail), .in_dest_i(b_dest), .in_data_i(b_data),
    .credit_o(credit_o), .fwd_vld_o(fwd_vld_o), .fwd_head_o(fwd_head_o),
    .fwd_tail_o(fwd_tail_o), .fwd_data_o(fwd_data_o), .out_cred_i(out_cred),
    .gnt_vld_o(gnt_vld_o), .gnt_src_o(gnt_src_o)
  );

  // {valid[3:0], dest3, dest2, dest1, dest0, exp_fire[3:0], chk_out, exp_src}
  localparam logic [34:0] VEC [6] = '{
    {4'b1111, 5'd3,  5'd2,  5'd1, 5'd0, 4'b1111, 5'd2,  2'd2},
    {4'b1111, 5'd5,  5'd5,  5'd5, 5'd5, 4'b0001, 5'd5,  2'd0},
    {4'b1010, 5'd5,  5'd0,  5'd5, 5'd0, 4'b0010, 5'd5,  2'd1},
    {4'b1100, 5'd31, 5'd31, 5'd0, 5'd0, 4'b0100, 5'd31, 2'd2},
    {4'b0111, 5'd0,  5'd8,  5'd7, 5'd7, 4'b0101, 5'd7,  2'd0},
    {4'b1001, 5'd7,  5'd0,  5'd0, 5'd7, 4'b1000, 5'd7,  2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int i, input bit v, input bit h, input bit t,
                     input int dst, input int dat);
    b_vld[i]           = v;
    b_head[i]          = h;
    b_tail[i]          = t;
    b_dest[i*5 +: 5]   = dst[4:0];
    b_data[i*16 +: 16] = dat[15:0];
  endtask

  task automatic clr();
    b_vld = '0;
  endtask

  function automatic logic [1:0] src_of(input int d);
    return gnt_src_o[d*2 +: 2];
  endfunction

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset gnt", gnt_vld_o, 32'h0);
    chk("R1 reset fwd", {28'h0, fwd_vld_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 post-reset gnt", gnt_vld_o, 32'h0);
    chk("R1 post-reset credit", {28'h0, credit_o}, 32'h0);

    // vector table: single-flit packets
    for (int e = 0; e < 6; e++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        put(i, VEC[e][31+i], 1'b1, 1'b1, int'(VEC[e][11+5*i +: 5]), e*16+i);
      @(negedge clk);
      clr();
      chk(e == 0 ? "R6 parallel fire" : "R5 arbitration fire",
          {28'h0, fwd_vld_o}, {28'h0, VEC[e][10:7]});
      chk("R2 grant valid", {31'h0, gnt_vld_o[VEC[e][6:2]]}, 32'h1);
      chk("R10 grant source", {30'h0, src_of(int'(VEC[e][6:2]))}, {30'h0, VEC[e][1:0]});
      @(negedge clk);
      chk("R3 credit return", {28'h0, credit_o}, {28'h0, VEC[e][10:7]});
      repeat (5) @(negedge clk);
    end

    // R4/R5: three-flit packet on output 9 with a competitor
    put(0, 1, 1, 0, 9, 16'h0100);
    put(1, 1, 1, 1, 9, 16'h0200);
    @(negedge clk);
    chk("R4 head grant", {30'h0, src_of(9)}, 32'd0);
    put(0, 1, 0, 0, 9, 16'h0101);
    put(1, 0, 0, 0, 9, 0);
    @(negedge clk);
    chk("R4 body grant", {30'h0, src_of(9)}, 32'd0);
    chk("R4 competitor waits", {31'h0, fwd_vld_o[1]}, 32'd0);
    put(0, 1, 0, 1, 9, 16'h0102);
    @(negedge clk);
    clr();
    chk("R4 tail grant", {30'h0, src_of(9)}, 32'd0);
    chk("R4 tail data", {16'h0, fwd_data_o[15:0]}, 32'h0102);
    @(negedge clk);
    chk("R5 pointer past owner", {30'h0, src_of(9)}, 32'd1);
    repeat (3) @(negedge clk);

    // R8/R7: downstream credits on output 12
    auto_ret = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (k >= 1) chk("R8 grant within budget", {31'h0, gnt_vld_o[12]}, 32'h1);
      put(0, 1, 1, 1, 12, k);
      @(negedge clk);
    end
    chk("R8 no grant at zero credit", {31'h0, gnt_vld_o[12]}, 32'h0);
    chk("R8 no forward at zero credit", {31'h0, fwd_vld_o[0]}, 32'h0);
    put(0, 1, 1, 1, 13, 16'h0055);
    @(negedge clk);
    clr();
    chk("R7 blocked follower no grant", {31'h0, gnt_vld_o[13]}, 32'h0);
    chk("R7 blocked queue no forward", {31'h0, fwd_vld_o[0]}, 32'h0);
    man_ret[12] = 1'b1;
    @(negedge clk);
    man_ret[12] = 1'b0;
    chk("R8 grant after credit return", {31'h0, gnt_vld_o[12]}, 32'h1);
    chk("R8 stalled flit data", {16'h0, fwd_data_o[15:0]}, 32'h4);
    @(negedge clk);
    chk("R7 follower released", {31'h0, gnt_vld_o[13]}, 32'h1);
    chk("R7 follower data", {16'h0, fwd_data_o[15:0]}, 32'h55);
    @(negedge clk);

    // R9: fill input 2 to depth behind a stalled output, then drain in order
    for (int k = 0; k < 8; k++) begin
      put(2, 1, 1, 1, 12, 16'h00A0 + k);
      @(negedge clk);
    end
    clr();
    chk("R9 full queue held", {31'h0, fwd_vld_o[2]}, 32'h0);
    chk("R3 no credit while held", {31'h0, credit_o[2]}, 32'h0);
    man_ret[12] = 1'b1;
    @(negedge clk);
    man_ret[12] = 1'b0;
    auto_ret    = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk("R9 drain valid", {31'h0, fwd_vld_o[2]}, 32'h1);
      chk("R9 drain order", {16'h0, fwd_data_o[47:32]}, 32'h00A0 + k);
      @(negedge clk);
    end
    chk("R9 queue empty after depth", {31'h0, fwd_vld_o[2]}, 32'h0);

    finish_sim();
  end
endmodule